// File: doc/BRIEF.md
# Flash Read Wait-State Sequencer

This block sits between a processor's read or fetch request port and a slow nonvolatile memory array. The array is modelled as combinational read data. The block accepts one read at a time and latches its address, its bank select and the current wait-state setting. It then holds the read until both the shared charge pump and the target bank report that they are ready. After that it counts out a programmable number of cycles, captures the array data and presents it with a single-cycle valid strobe.

A 4-bit wait-state register sets the timed phase of every access. The register leaves reset at 15, the slowest value, and the surrounding system writes it through a write strobe. Each access uses the value the register held when that access was accepted. When an access is accepted, the block also raises a one-cycle access pulse that carries the bank number, so that a power manager can restart its idle timers for that bank. The pulse is raised even when the access then has to wait for readiness.

The control is a four-state machine:

- IDLE waits for a request.
- STALL waits for the pump and the bank to be ready.
- TIME counts down the wait states.
- DONE presents the data.

The transitions are:

- IDLE to TIME: a request arrives while the pump and the target bank are both ready.
- IDLE to STALL: a request arrives while either of them is not ready.
- STALL to TIME: the pump and the latched bank both become ready.
- TIME to DONE: the down-counter reaches zero.
- DONE to IDLE: always, after one cycle.

Top module: `flash_rd_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in IDLE with busy, data-valid and the access pulse all low. It also sets the wait-state register to 15, so the first read after reset with both ready flags high returns data 16 cycles after acceptance.
- R2: In IDLE, a request is accepted at a clock edge where the request input is high. Busy is high in the next cycle. The access pulse is high for exactly that one cycle, with the access bank output equal to the requested bank number.
- R3: When the pump and the target bank are ready at acceptance, data-valid rises exactly setting+1 clock edges after the acceptance edge. The read data then equals the array data at the latched bank and address.
- R4: While the pump-ready input is low, the timed phase does not begin. Data-valid rises setting+1 edges after the first edge at which the pump and the target bank are both sampled ready.
- R5: Only the ready flag of the target bank (bit index equal to the bank select) gates the access. The ready flags of the other banks have no effect on latency. A low ready flag on the target bank stalls the access in the same way as the pump flag does.
- R6: The wait-state setting is sampled at acceptance. A write to the wait-state register during an access does not change that access's latency, and the new value applies from the next accepted access onwards.
- R7: Only one read is outstanding at a time. A request made while busy is high, including the cycle in which data-valid is high, is not accepted: it produces no access pulse and no extra data-valid.
- R8: Data-valid is high for exactly one cycle, and busy is low in the cycle after it. A reset in the middle of an access cancels it, so no data-valid follows.
- R9: The array address output holds the latched request address unchanged from acceptance until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request |
| req_addr_i | input | ADDR_W | Read address within the bank |
| req_bank_i | input | BANK_W | Target bank number |
| ws_we_i | input | 1 | Write strobe for the wait-state register |
| ws_val_i | input | WS_W | New wait-state value |
| bank_rdy_i | input | NUM_BANKS | Per-bank ready flags, bit n for bank n |
| pump_rdy_i | input | 1 | Shared charge pump ready |
| arr_addr_o | output | ADDR_W | Address presented to the array |
| arr_bank_o | output | BANK_W | Bank presented to the array |
| arr_data_i | input | DATA_W | Combinational array read data |
| busy_o | output | 1 | High whenever the block is not in IDLE |
| rvalid_o | output | 1 | One-cycle read-data-valid strobe |
| rdata_o | output | DATA_W | Captured read data |
| acc_pulse_o | output | 1 | One-cycle access notification |
| acc_bank_o | output | BANK_W | Bank number carried with the access pulse |

## Verification
The assertions check the following on every cycle:

- Acceptance from idle is followed by busy and a single access pulse.
- No access pulse appears after a busy cycle.
- Data-valid lasts one cycle and is followed by idle.
- The array address stays steady through an access.
- Reset clears the outputs.

Only the bench scenarios can show the exact cycle counts: setting+1 latency, the stall on the pump or the bank followed by the timed phase, and a mid-access write that leaves the current latency alone. The bench also shows that the data returned matches the array at the latched address.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_TIME  = 2'd2,
        ST_DONE  = 2'd3
    } rd_state_t;

endpackage

// File: rtl/flash_rd_rdy_sel.sv
// Combines the shared pump flag with the flag of one selected bank.
module flash_rd_rdy_sel #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 2
) (
    input  logic [NUM_BANKS-1:0] bank_rdy_i,
    input  logic                 pump_rdy_i,
    input  logic [BANK_W-1:0]    sel_i,
    output logic                 rdy_o
);

    logic [NUM_BANKS-1:0] hit;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign hit[g] = (sel_i == BANK_W'(g)) && bank_rdy_i[g];
    end

    assign rdy_o = pump_rdy_i && (|hit);

endmodule

// File: rtl/flash_rd_wait_ctr.sv
// Loadable down-counter for the timed read phase.
module flash_rd_wait_ctr #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [WS_W-1:0] load_val_i,
    input  logic            dec_i,
    output logic            zero_o
);

    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/flash_rd_req_latch.sv
// Holds the address, bank and wait setting of the accepted request.
module flash_rd_req_latch #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [WS_W-1:0]   ws_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [WS_W-1:0]   ws_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            bank_o <= '0;
            ws_o   <= '0;
        end else if (cap_i) begin
            addr_o <= addr_i;
            bank_o <= bank_i;
            ws_o   <= ws_i;
        end
    end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3,
    parameter int WS_W      = 4,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [BANK_W-1:0]    req_bank_i,
    input  logic                 ws_we_i,
    input  logic [WS_W-1:0]      ws_val_i,
    input  logic [NUM_BANKS-1:0] bank_rdy_i,
    input  logic                 pump_rdy_i,
    output logic [ADDR_W-1:0]    arr_addr_o,
    output logic [BANK_W-1:0]    arr_bank_o,
    input  logic [DATA_W-1:0]    arr_data_i,
    output logic                 busy_o,
    output logic                 rvalid_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 acc_pulse_o,
    output logic [BANK_W-1:0]    acc_bank_o
);
    import flash_rd_pkg::*;

    localparam logic [WS_W-1:0] WS_RESET = {WS_W{1'b1}};

    rd_state_t         state_q, state_d;
    logic [WS_W-1:0]   ws_q;
    logic [WS_W-1:0]   ws_lat;
    logic [ADDR_W-1:0] addr_lat;
    logic [BANK_W-1:0] bank_lat;
    logic [BANK_W-1:0] rdy_sel;
    logic              rdy;
    logic              accept;
    logic              ctr_load;
    logic              ctr_dec;
    logic              ctr_zero;
    logic [WS_W-1:0]   ctr_val;
    logic [DATA_W-1:0] data_q;
    logic              pulse_q;

    assign accept  = (state_q == ST_IDLE) && req_i;
    assign rdy_sel = (state_q == ST_IDLE) ? req_bank_i : bank_lat;

    flash_rd_rdy_sel #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_rdy (
        .bank_rdy_i (bank_rdy_i),
        .pump_rdy_i (pump_rdy_i),
        .sel_i      (rdy_sel),
        .rdy_o      (rdy)
    );

    flash_rd_req_latch #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .WS_W   (WS_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (accept),
        .addr_i (req_addr_i),
        .bank_i (req_bank_i),
        .ws_i   (ws_q),
        .addr_o (addr_lat),
        .bank_o (bank_lat),
        .ws_o   (ws_lat)
    );

    // The counter loads when the timed phase starts: straight from IDLE
    // (current register value) or from STALL (value latched at acceptance).
    assign ctr_load = (accept && rdy) || ((state_q == ST_STALL) && rdy);
    assign ctr_val  = (state_q == ST_IDLE) ? ws_q : ws_lat;
    assign ctr_dec  = (state_q == ST_TIME) && !ctr_zero;

    flash_rd_wait_ctr #(
        .WS_W (WS_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (ctr_val),
        .dec_i      (ctr_dec),
        .zero_o     (ctr_zero)
    );

    // Wait-state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= WS_RESET;
        end else if (ws_we_i) begin
            ws_q <= ws_val_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i)    state_d = rdy ? ST_TIME : ST_STALL;
            ST_STALL: if (rdy)      state_d = ST_TIME;
            ST_TIME:  if (ctr_zero) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data capture and access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= accept;
            if ((state_q == ST_TIME) && ctr_zero) begin
                data_q <= arr_data_i;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o   = 1'b1;
        rvalid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o   = 1'b0;
            ST_STALL: busy_o   = 1'b1;
            ST_TIME:  busy_o   = 1'b1;
            ST_DONE:  rvalid_o = 1'b1;
            default:  busy_o   = 1'b1;
        endcase
    end

    assign arr_addr_o  = addr_lat;
    assign arr_bank_o  = bank_lat;
    assign rdata_o     = data_q;
    assign acc_pulse_o = pulse_q;
    assign acc_bank_o  = bank_lat;

endmodule

// File: rtl/flash_rd_seq_chk.sv
module flash_rd_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              busy_o,
    input logic              rvalid_o,
    input logic              acc_pulse_o,
    input logic [ADDR_W-1:0] arr_addr_o
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !rvalid_o && !acc_pulse_o));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> (busy_o && acc_pulse_o));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse_o |=> !acc_pulse_o);

    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !acc_pulse_o);

    p_rvalid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> (!rvalid_o && !busy_o));

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !acc_pulse_o) |-> $stable(arr_addr_o));

endmodule

bind flash_rd_seq flash_rd_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .busy_o      (busy_o),
    .rvalid_o    (rvalid_o),
    .acc_pulse_o (acc_pulse_o),
    .arr_addr_o  (arr_addr_o)
);

// File: tb/tb_flash_rd_seq.sv
module tb_flash_rd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NB     = 3;
    localparam int BW     = 2;
    localparam int WSW    = 4;

    // vector: {ws[27:24], bank[23:22], kind[21:20], stall[19:16], addr[15:0]}
    // kind 0: pump low for 'stall' cycles; 1: target bank low; 2: other banks low
    localparam int NVEC = 8;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0,  2'd0, 2'd0, 4'd0, 16'h0010},
        {4'd3,  2'd1, 2'd0, 4'd0, 16'h1234},
        {4'd7,  2'd2, 2'd0, 4'd0, 16'hBEEF},
        {4'd15, 2'd0, 2'd0, 4'd0, 16'hFFFF},
        {4'd2,  2'd1, 2'd0, 4'd5, 16'h0A0A},
        {4'd0,  2'd2, 2'd0, 4'd3, 16'h7777},
        {4'd4,  2'd0, 2'd1, 4'd6, 16'h4321},
        {4'd1,  2'd2, 2'd2, 4'd0, 16'h0F0F}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [BW-1:0]     req_bank_i = '0;
    logic              ws_we_i = 1'b0;
    logic [WSW-1:0]    ws_val_i = '0;
    logic [NB-1:0]     bank_rdy_i = '1;
    logic              pump_rdy_i = 1'b1;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [BW-1:0]     arr_bank_o;
    logic [DATA_W-1:0] arr_data_i;
    logic              busy_o;
    logic              rvalid_o;
    logic [DATA_W-1:0] rdata_o;
    logic              acc_pulse_o;
    logic [BW-1:0]     acc_bank_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] fdata(input logic [BW-1:0] b,
                                                input logic [ADDR_W-1:0] a);
        return {a ^ 16'h5A3C, a + {14'h0, b}};
    endfunction

    assign arr_data_i = fdata(arr_bank_o, arr_addr_o);

    flash_rd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NB), .WS_W(WSW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
        .req_bank_i(req_bank_i), .ws_we_i(ws_we_i), .ws_val_i(ws_val_i),
        .bank_rdy_i(bank_rdy_i), .pump_rdy_i(pump_rdy_i),
        .arr_addr_o(arr_addr_o), .arr_bank_o(arr_bank_o), .arr_data_i(arr_data_i),
        .busy_o(busy_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
        .acc_pulse_o(acc_pulse_o), .acc_bank_o(acc_bank_o)
    );

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ws(input logic [WSW-1:0] v);
        @(negedge clk);
        ws_we_i  = 1'b1;
        ws_val_i = v;
        @(negedge clk);
        ws_we_i  = 1'b0;
    endtask

    // kind 0: pump low until released; 1: target bank low; 2: others low
    // mid_ws: if >=0, write this wait value one cycle after acceptance
    task automatic do_read(input logic [BW-1:0] bank, input logic [ADDR_W-1:0] addr,
                           input int kind, input int stall, input int exp_lat,
                           input bit hold_req, input int mid_ws, input string req);
        int k;
        int extra_pulse;
        int extra_valid;
        @(negedge clk);
        req_i      = 1'b1;
        req_bank_i = bank;
        req_addr_i = addr;
        pump_rdy_i = 1'b1;
        bank_rdy_i = '1;
        if (kind == 0 && stall > 0) pump_rdy_i = 1'b0;
        if (kind == 1 && stall > 0) bank_rdy_i = ~(NB'(1) << bank);
        if (kind == 2) bank_rdy_i = NB'(1) << bank;
        @(posedge clk);
        @(negedge clk);
        if (!hold_req) req_i = 1'b0;
        req_bank_i = bank + 2'd1;
        req_addr_i = ~addr;
        check(acc_pulse_o && busy_o && acc_bank_o == bank, "R2", {acc_pulse_o, busy_o, acc_bank_o},
              {1'b1, 1'b1, bank});
        if (mid_ws >= 0) begin
            ws_we_i  = 1'b1;
            ws_val_i = WSW'(mid_ws);
        end
        k = 0;
        extra_pulse = 0;
        while (!rvalid_o && k < 100) begin
            if (stall > 0 && k == stall - 1) begin
                pump_rdy_i = 1'b1;
                if (kind == 1) bank_rdy_i = '1;
            end
            @(posedge clk);
            @(negedge clk);
            ws_we_i = 1'b0;
            k++;
            if (acc_pulse_o) extra_pulse++;
        end
        check(k == exp_lat, req, k, exp_lat);
        check(rdata_o == fdata(bank, addr), "R3", rdata_o, fdata(bank, addr));
        req_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        extra_valid = rvalid_o ? 1 : 0;
        check(!busy_o && extra_valid == 0, "R8", {busy_o, rvalid_o}, 0);
        if (hold_req) check(extra_pulse == 0 && !acc_pulse_o, "R7", extra_pulse, 0);
        bank_rdy_i = '1;
        pump_rdy_i = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !rvalid_o && !acc_pulse_o, "R1",
              {busy_o, rvalid_o, acc_pulse_o}, 0);
        rst_n = 1'b1;

        // R1: reset wait setting is 15 -> latency 16
        do_read(2'd1, 16'h00AA, 0, 0, 16, 1'b0, -1, "R1");

        // Vector table: R3 latency, R4 pump stall, R5 bank gating
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            int exp;
            string tag;
            v = VEC[i];
            write_ws(v[27:24]);
            exp = int'(v[19:16]) + int'(v[27:24]) + 1;
            if (v[21:20] == 2'd1 || v[21:20] == 2'd2) tag = "R5";
            else if (v[19:16] != 0) tag = "R4";
            else tag = "R3";
            do_read(v[23:22], v[15:0], int'(v[21:20]), int'(v[19:16]), exp,
                    1'b0, -1, tag);
        end

        // R6: write during access does not change it; next access uses new value
        write_ws(4'd3);
        do_read(2'd0, 16'h3333, 0, 0, 4, 1'b0, 9, "R6");
        do_read(2'd2, 16'h4444, 0, 0, 10, 1'b0, -1, "R6");

        // R7: request held high through the whole access is not re-accepted
        write_ws(4'd2);
        do_read(2'd1, 16'h5555, 0, 0, 3, 1'b1, -1, "R7");

        // R9: address presented to array during a stalled access
        @(negedge clk);
        req_i = 1'b1; req_bank_i = 2'd2; req_addr_i = 16'hCAFE; pump_rdy_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; req_addr_i = 16'h0000;
        repeat (3) @(negedge clk);
        check(arr_addr_o == 16'hCAFE && arr_bank_o == 2'd2, "R9", arr_addr_o, 16'hCAFE);

        // R8: reset mid-access cancels it and restores wait setting 15 (R1)
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pump_rdy_i = 1'b1;
        check(!busy_o && !rvalid_o, "R8", {busy_o, rvalid_o}, 0);
        begin
            int seen;
            seen = 0;
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (rvalid_o || busy_o) seen++;
            end
            check(seen == 0, "R8", seen, 0);
        end
        do_read(2'd0, 16'h9999, 0, 0, 16, 1'b0, -1, "R1");

        finish_run();
    end

endmodule